// File: doc/BRIEF.md
# Chip-Select Region Access Sequencer

This block performs one external parallel-bus access, a read or a write, for a single chip-select region. A host raises a request with a direction, an address and write data. The block drives the bus pins through five timed phases: address setup, a chip-enable lead-in, the read or write strobe, a hold before chip enable is released, and a closing pause. It then pulses an acknowledge. On a read, the value captured from the bus is presented on `rdata` at the same moment.

Every phase length comes from a timing word loaded through a single load port. Each field gives a count of units. A two-bit encoded multiplier sets how many base clocks one unit lasts, so one word can serve slow and fast devices without wider fields. In wait mode the device's ready line holds the strobe open. A further programmable span then keeps the strobe, and any write data, active after ready returns. A region whose enable bit is clear ignores requests.

Top module: `cs_region_seq`

## Requirements
- R1: While `rst_n` is low and after reset, the pins are idle: `bus_ce_n`, `bus_oe_n` and `bus_we_n` are high, `bus_doe` and `ack` are low and `rdata` is zero. The timing word resets to all zeros, so the region starts disabled.
- R2: Timing word layout (FW = phase field width): bit 0 enables the region, bit 1 selects wait mode, bits 3:2 hold the multiplier code. From bit 4 upward, FW-bit fields follow in this order: address setup, CE lead-in, read strobe, read hold, write strobe, write hold, pause, ready wait.
- R3: The multiplier code maps 0 to 4, 1 to 1, 2 to 2 and 3 to 8. A phase whose field holds value f lasts (f+1) times that multiplier in clocks.
- R4: The phases run in a fixed order. Address setup has CE high. The lead-in has CE low with no strobe. Then come the strobe, the hold with CE low and no strobe, and the pause with CE high. `bus_addr` takes the request address when the access starts and stays unchanged while CE is low.
- R5: A read asserts only `bus_oe_n` and times its strobe and hold from the read fields. A write asserts only `bus_we_n` and uses the write fields.
- R6: `bus_rdy` passes through a two-flop synchronizer. In wait mode, the strobe's final clock repeats while the synchronized ready is low. The strobe then stays active for the ready-wait span. Without wait mode, `bus_rdy` has no effect on timing.
- R7: On a read, `bus_din` is captured at the clock edge that ends the strobe. The value shows on `rdata` when `ack` is high and holds until the next read capture.
- R8: On a write, `bus_doe` is high and `bus_dout` carries the request data from the first CE-low clock through the last hold clock. On a read, `bus_doe` stays low.
- R9: `ack` is high for exactly one clock, right after the last pause clock. A request is only accepted while the block is idle and `ack` is low. A request held through `ack` therefore starts one access, not two.
- R10: While the enable bit is clear, a request starts no access: CE stays high and `ack` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Load `cfg_word` into the timing register |
| cfg_word | input | 4+8*FW | Timing word (layout in R2) |
| req | input | 1 | Access request, level, held until `ack` |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| ack | output | 1 | One-clock completion pulse |
| rdata | output | DW | Captured read data |
| bus_addr | output | AW | External address |
| bus_ce_n | output | 1 | Chip enable, active low |
| bus_oe_n | output | 1 | Output enable (read strobe), active low |
| bus_we_n | output | 1 | Write enable, active low |
| bus_dout | output | DW | Write data to the bus |
| bus_doe | output | 1 | Drive enable for `bus_dout` |
| bus_din | input | DW | Read data from the bus |
| bus_rdy | input | 1 | Device ready, asynchronous |

## Verification
Some pin rules hold on every clock, and the assertions check those. A strobe never appears outside CE, and the two strobes are never active together. Write data is never driven outside CE or during a read strobe. The address is steady while CE is low, and `ack` is a single clock that falls while CE is high. Phase lengths are checked only by the bench's scenarios: under each multiplier code, for each direction, with the ready stall and wait extension, and with ready ignored when wait mode is off. The same goes for the exact read capture edge, the refusal of a disabled region, and the single access per held request.

// File: rtl/cs_region_seq.sv
module cs_region_seq #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int FW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [4+8*FW-1:0] cfg_word,
  input  logic              req,
  input  logic              req_wr,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              ack,
  output logic [DW-1:0]     rdata,
  output logic [AW-1:0]     bus_addr,
  output logic              bus_ce_n,
  output logic              bus_oe_n,
  output logic              bus_we_n,
  output logic [DW-1:0]     bus_dout,
  output logic              bus_doe,
  input  logic [DW-1:0]     bus_din,
  input  logic              bus_rdy
);
  localparam int CFGW = 4 + 8*FW;
  localparam int CW   = FW + 4;

  typedef enum logic [2:0] {S_IDLE, S_ADR, S_LEAD, S_STB, S_EXT, S_HLD, S_PAU} st_t;

  st_t             state;
  logic [CFGW-1:0] cfg;
  logic [CW-1:0]   cnt;
  logic            wr_q, rdy_s1, rdy_s2;
  logic [DW-1:0]   wdata;
  logic [1:0]      shamt;

  logic [FW-1:0] f_adr, f_lead, f_rstb, f_rhld, f_wstb, f_whld, f_pau, f_rwait;
  assign f_adr   = cfg[4+0*FW +: FW];
  assign f_lead  = cfg[4+1*FW +: FW];
  assign f_rstb  = cfg[4+2*FW +: FW];
  assign f_rhld  = cfg[4+3*FW +: FW];
  assign f_wstb  = cfg[4+4*FW +: FW];
  assign f_whld  = cfg[4+5*FW +: FW];
  assign f_pau   = cfg[4+6*FW +: FW];
  assign f_rwait = cfg[4+7*FW +: FW];

  wire en_bit   = cfg[0];
  wire wait_bit = cfg[1];

  always_comb begin
    case (cfg[3:2])
      2'd0:    shamt = 2'd2;
      2'd1:    shamt = 2'd0;
      2'd2:    shamt = 2'd1;
      default: shamt = 2'd3;
    endcase
  end

  function automatic logic [CW-1:0] span(input logic [FW-1:0] f, input logic [1:0] sh);
    return ((CW'(f) + CW'(1)) << sh) - CW'(1);
  endfunction

  wire [FW-1:0] stb_f = wr_q ? f_wstb : f_rstb;
  wire [FW-1:0] hld_f = wr_q ? f_whld : f_rhld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cfg      <= '0;
      cnt      <= '0;
      wr_q     <= 1'b0;
      wdata    <= '0;
      bus_addr <= '0;
      rdata    <= '0;
      ack      <= 1'b0;
      rdy_s1   <= 1'b0;
      rdy_s2   <= 1'b0;
    end else begin
      rdy_s1 <= bus_rdy;
      rdy_s2 <= rdy_s1;
      ack    <= 1'b0;
      if (cfg_load) cfg <= cfg_word;
      if (state == S_IDLE) begin
        if (req && en_bit && !ack) begin
          state    <= S_ADR;
          cnt      <= span(f_adr, shamt);
          wr_q     <= req_wr;
          bus_addr <= req_addr;
          wdata    <= req_wdata;
        end
      end else if (cnt != '0) begin
        cnt <= cnt - CW'(1);
      end else begin
        case (state)
          S_ADR: begin
            state <= S_LEAD;
            cnt   <= span(f_lead, shamt);
          end
          S_LEAD: begin
            state <= S_STB;
            cnt   <= span(stb_f, shamt);
          end
          S_STB: begin
            if (wait_bit) begin
              if (rdy_s2) begin
                state <= S_EXT;
                cnt   <= span(f_rwait, shamt);
              end
            end else begin
              state <= S_HLD;
              cnt   <= span(hld_f, shamt);
              if (!wr_q) rdata <= bus_din;
            end
          end
          S_EXT: begin
            state <= S_HLD;
            cnt   <= span(hld_f, shamt);
            if (!wr_q) rdata <= bus_din;
          end
          S_HLD: begin
            state <= S_PAU;
            cnt   <= span(f_pau, shamt);
          end
          default: begin
            state <= S_IDLE;
            ack   <= 1'b1;
          end
        endcase
      end
    end
  end

  wire ce_on  = (state == S_LEAD) || (state == S_STB) || (state == S_EXT) || (state == S_HLD);
  wire stb_on = (state == S_STB) || (state == S_EXT);

  assign bus_ce_n = !ce_on;
  assign bus_oe_n = !(stb_on && !wr_q);
  assign bus_we_n = !(stb_on && wr_q);
  assign bus_doe  = ce_on && wr_q;
  assign bus_dout = wdata;
endmodule

// File: rtl/cs_region_seq_chk.sv
module cs_region_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ack,
  input logic [AW-1:0] bus_addr,
  input logic          bus_ce_n,
  input logic          bus_oe_n,
  input logic          bus_we_n,
  input logic          bus_doe
);
  // R4
  strobe_in_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_oe_n || !bus_we_n) |-> !bus_ce_n);

  // R5
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_oe_n && !bus_we_n));

  // R8
  drive_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_doe |-> (!bus_ce_n && bus_oe_n));

  // R4
  addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ce_n |-> $stable(bus_addr));

  // R9
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  // R9
  ack_ce_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> bus_ce_n);
endmodule

bind cs_region_seq cs_region_seq_chk #(.AW(AW)) u_chk (.*);

// File: tb/test_cs_region_seq.sv
module test_cs_region_seq;
  localparam int AW = 16, DW = 16, FW = 6, CFGW = 4 + 8*FW;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic cfg_load = 1'b0;
  logic [CFGW-1:0] cfg_word = '0;
  logic req = 1'b0, req_wr = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic ack, bus_ce_n, bus_oe_n, bus_we_n, bus_doe;
  logic [DW-1:0] rdata, bus_dout;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_din = '0;
  logic bus_rdy = 1'b1;

  cs_region_seq #(.AW(AW), .DW(DW), .FW(FW)) i_cs_region_seq (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_word(cfg_word),
    .req(req), .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata),
    .ack(ack), .rdata(rdata), .bus_addr(bus_addr), .bus_ce_n(bus_ce_n),
    .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n), .bus_dout(bus_dout),
    .bus_doe(bus_doe), .bus_din(bus_din), .bus_rdy(bus_rdy));

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int c_en = 0, c_wm = 0, c_mul = 0;
  int f_adr = 0, f_lead = 0, f_rstb = 0, f_rhld = 0, f_wstb = 0, f_whld = 0, f_pau = 0, f_rwait = 0;

  function automatic int mfac(int e);
    case (e)
      0: return 4;
      1: return 1;
      2: return 2;
      default: return 8;
    endcase
  endfunction

  function automatic int units(int f);
    return (f + 1) * mfac(c_mul);
  endfunction

  function automatic int total(bit wr);
    int t;
    t = units(f_adr) + units(f_lead) + units(wr ? f_wstb : f_rstb)
      + units(wr ? f_whld : f_rhld) + units(f_pau);
    if (c_wm != 0) t += units(f_rwait);
    return t;
  endfunction

  // R2 layout, bit positions stated in the requirement
  function automatic logic [CFGW-1:0] pack();
    logic [CFGW-1:0] v;
    v = '0;
    v[0] = c_en[0];
    v[1] = c_wm[0];
    v[3:2] = c_mul[1:0];
    v[4+0*FW +: FW] = f_adr[FW-1:0];
    v[4+1*FW +: FW] = f_lead[FW-1:0];
    v[4+2*FW +: FW] = f_rstb[FW-1:0];
    v[4+3*FW +: FW] = f_rhld[FW-1:0];
    v[4+4*FW +: FW] = f_wstb[FW-1:0];
    v[4+5*FW +: FW] = f_whld[FW-1:0];
    v[4+6*FW +: FW] = f_pau[FW-1:0];
    v[4+7*FW +: FW] = f_rwait[FW-1:0];
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // behavioural reference: phase number 0 idle, 1 setup, 2 lead-in, 3 strobe, 4 ready wait, 5 hold, 6 pause
  int ph = 0, rem = 0;
  bit m_wr = 1'b0, e_ack = 1'b0, sy1 = 1'b0, sy2 = 1'b0, started = 1'b0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_wd = '0, e_rd = '0;

  always @(posedge clk) begin : model
    bit old_sy, nack;
    started = 1'b1;
    if (!rst_n) begin
      ph = 0; rem = 0; e_ack = 1'b0; sy1 = 1'b0; sy2 = 1'b0;
      e_rd = '0; m_wr = 1'b0; m_addr = '0; m_wd = '0;
    end else begin
      old_sy = sy2; sy2 = sy1; sy1 = bus_rdy;
      nack = 1'b0;
      if (ph == 0) begin
        if (req && c_en != 0 && !e_ack) begin
          ph = 1; rem = units(f_adr);
          m_wr = req_wr; m_addr = req_addr; m_wd = req_wdata;
        end
      end else if (rem > 1) begin
        rem--;
      end else if (ph == 3 && c_wm != 0 && !old_sy) begin
        rem = 1;
      end else begin
        case (ph)
          1: begin ph = 2; rem = units(f_lead); end
          2: begin ph = 3; rem = units(m_wr ? f_wstb : f_rstb); end
          3, 4: begin
            if (ph == 3 && c_wm != 0) begin
              ph = 4; rem = units(f_rwait);
            end else begin
              if (!m_wr) e_rd = bus_din;
              ph = 5; rem = units(m_wr ? f_whld : f_rhld);
            end
          end
          5: begin ph = 6; rem = units(f_pau); end
          default: begin ph = 0; nack = 1'b1; end
        endcase
      end
      e_ack = nack;
    end
  end

  always @(negedge clk) begin : compare
    bit s_ce, s_st;
    if (started) begin
      cyc++;
      s_ce = (ph >= 2 && ph <= 5);
      s_st = (ph == 3 || ph == 4);
      chk(bus_ce_n == !s_ce, "R4", "ce_n", int'(bus_ce_n), int'(!s_ce));
      chk(bus_oe_n == !(s_st && !m_wr), "R5 R6", "oe_n", int'(bus_oe_n), int'(!(s_st && !m_wr)));
      chk(bus_we_n == !(s_st && m_wr), "R5 R6", "we_n", int'(bus_we_n), int'(!(s_st && m_wr)));
      chk(bus_doe == (s_ce && m_wr), "R8", "doe", int'(bus_doe), int'(s_ce && m_wr));
      if (s_ce) chk(bus_addr == m_addr, "R4", "addr", int'(bus_addr), int'(m_addr));
      if (s_ce && m_wr) chk(bus_dout == m_wd, "R8", "dout", int'(bus_dout), int'(m_wd));
      chk(ack == e_ack, "R9", "ack", int'(ack), int'(e_ack));
      chk(rdata == e_rd, "R7", "rdata", int'(rdata), int'(e_rd));
      bus_din = DW'(32'h5A00 ^ cyc);
      if (cyc > 150000) begin
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  task automatic load_cfg();
    @(negedge clk);
    cfg_load = 1'b1;
    cfg_word = pack();
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input int exp, input string tag, output int n);
    @(negedge clk);
    req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!ack && n < 4000);
    req = 1'b0;
    chk(ack == 1'b1, tag, "ack seen", int'(ack), 1);
    if (exp >= 0) chk(n == exp + 1, tag, "latency", n, exp + 1);
  endtask

  task automatic set_fields(input int a, input int l, input int rs, input int rh,
                            input int ws, input int wh, input int p, input int w);
    f_adr = a; f_lead = l; f_rstb = rs; f_rhld = rh;
    f_wstb = ws; f_whld = wh; f_pau = p; f_rwait = w;
  endtask

  initial begin
    int n, acks;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(bus_ce_n && bus_oe_n && bus_we_n && !bus_doe && !ack && rdata == '0, "R1", "idle pins in reset",
        int'({bus_ce_n, bus_oe_n, bus_we_n, bus_doe, ack}), 5'b11100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bus_ce_n && !ack, "R1", "idle after reset", int'({bus_ce_n, ack}), 2'b10);

    // R10 disabled region after reset, then with fields loaded but enable clear
    for (int k = 0; k < 2; k++) begin
      if (k == 1) begin set_fields(1, 1, 2, 1, 2, 1, 1, 0); c_mul = 1; load_cfg(); end
      acks = 0;
      @(negedge clk); req = 1'b1; req_wr = 1'b0; req_addr = 16'h1234;
      for (int i = 0; i < 30; i++) begin @(negedge clk); if (ack || !bus_ce_n) acks++; end
      req = 1'b0;
      chk(acks == 0, "R10", "no access while disabled", acks, 0);
    end

    // R3 R5 each multiplier code, both directions
    c_en = 1; c_wm = 0;
    for (int m = 0; m < 4; m++) begin
      c_mul = m;
      set_fields(m, 1, 2 + m, 1, 3, m, 2, 0);
      load_cfg();
      access(1'b1, AW'(16'h0100 + m), DW'(16'hC0DE ^ m), total(1'b1), "R3 R2 write", n);
      access(1'b0, AW'(16'h0200 + m), '0, total(1'b0), "R3 R5 read", n);
    end

    // R5 asymmetric read/write fields, zero fields give one unit
    c_mul = 1;
    set_fields(0, 0, 7, 0, 0, 5, 0, 0);
    load_cfg();
    access(1'b0, 16'hAAAA, '0, total(1'b0), "R5 read fields", n);
    access(1'b1, 16'h5555, 16'h1357, total(1'b1), "R5 write fields", n);

    // R6 ready ignored without wait mode
    bus_rdy = 1'b0;
    access(1'b0, 16'h0033, '0, total(1'b0), "R6 ready ignored", n);
    access(1'b1, 16'h0034, 16'h2468, total(1'b1), "R6 ready ignored", n);
    bus_rdy = 1'b1;

    // R6 wait mode with ready already high adds the ready-wait span
    c_wm = 1; c_mul = 2;
    set_fields(1, 0, 1, 1, 2, 0, 1, 2);
    load_cfg();
    repeat (4) @(negedge clk);
    access(1'b0, 16'h0777, '0, total(1'b0), "R6 wait span read", n);
    access(1'b1, 16'h0778, 16'hBEEF, total(1'b1), "R6 wait span write", n);

    // R6 R7 ready held low stretches the strobe
    bus_rdy = 1'b0;
    fork
      access(1'b0, 16'h0999, '0, -1, "R6 stall read", n);
      begin repeat (25) @(negedge clk); bus_rdy = 1'b1; end
    join
    chk(n > total(1'b0) + 10, "R6", "stall lengthens access", n, total(1'b0) + 11);
    bus_rdy = 1'b0;
    fork
      access(1'b1, 16'h099A, 16'h4321, -1, "R6 stall write", n);
      begin repeat (18) @(negedge clk); bus_rdy = 1'b1; end
    join
    chk(n > total(1'b1) + 5, "R6", "stall lengthens write", n, total(1'b1) + 6);

    // R9 request held through ack starts exactly one access
    c_wm = 0; c_mul = 1;
    set_fields(0, 0, 0, 0, 0, 0, 0, 0);
    load_cfg();
    acks = 0;
    @(negedge clk); req = 1'b1; req_wr = 1'b0; req_addr = 16'h0042;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (ack) begin acks++; req = 1'b0; end
    end
    req = 1'b0;
    chk(acks == 1, "R9", "single ack per request", acks, 1);

    // R10 disabling again blocks requests
    c_en = 0;
    load_cfg();
    acks = 0;
    @(negedge clk); req = 1'b1;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (ack) acks++; end
    req = 1'b0;
    chk(acks == 0, "R10", "no ack after disable", acks, 0);

    repeat (5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule